// File: doc/BRIEF.md
# Segmented-Carry Loadable Up/Down Counter

This block is a synchronous binary counter, 16 bits wide by default, that counts up or down by one. It can be preset from a parallel value, paused with a clock enable, and cleared at once by an asynchronous clear. There is no full-width adder. The count is split into 2-bit slices, and each slice passes a single carry to the slice above it. A slice raises its carry when three things line up: its own carry-in, the direction, and both of its bits being at the end value for that direction (both ones when counting up, both zeros when counting down). The carry-in of the lowest slice is the clock enable, so a low enable stops the whole chain.

The carry out of the top slice leaves the block as a terminal-count flag. A wider counter can be built by feeding that flag into the clock enable of a second counter. The clear takes effect without a clock edge. The clear is released in step with the clock, so the count stays at zero for the first two rising edges after the clear input falls.

Top module: `gcnt_top`

## Requirements
- R1: While `rst_i` is high the count is 0x0000, and a rise of `rst_i` between clock edges clears the count before the next edge.
- R2: After `rst_i` falls, the count stays 0x0000 through the first two rising clock edges, whatever the other inputs are. The third edge is the first one that can load or count.
- R3: On a rising edge with `ld_i` high, the count takes `ld_val_i`, whatever `ce_i` and `up_i` are.
- R4: On a rising edge with `ld_i` low and `ce_i` low, the count keeps its value.
- R5: On a rising edge with `ld_i` low, `ce_i` high and `up_i` high, the count becomes the old count plus one modulo 2^16, so 0xFFFF is followed by 0x0000.
- R6: On a rising edge with `ld_i` low, `ce_i` high and `up_i` low, the count becomes the old count minus one modulo 2^16, so 0x0000 is followed by 0xFFFF.
- R7: `tc_o` is combinational and does not depend on `ld_i`. It is high exactly when `ce_i` is high and either `up_i` is high with the count at 0xFFFF, or `up_i` is low with the count at 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Asynchronous clear, active high, released in step with the clock |
| ce_i | input | 1 | Count enable, active high; this is the carry-in of the lowest slice |
| ld_i | input | 1 | Parallel preset, active high; has priority over counting |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| ld_val_i | input | CNT_W | Value taken on a preset |
| cnt_o | output | CNT_W | Current count |
| tc_o | output | 1 | Carry out of the top slice (terminal count) |

## Verification
The bench presets values next to both wrap points and then counts across them in each direction. A slice whose carry uses the wrong end value shows up here: it either skips from 0xFFFF to a nonzero value or fails to borrow through 0x0000. Presets are issued with the enable both low and high, which catches a design that lets counting win over the preset. The bench also raises the clear in the middle of a cycle, which exposes a clear that waits for a clock edge. It then loads during the two edges right after the clear falls, which exposes a release that is not synchronized or that lasts the wrong number of cycles.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;
  // width of one carry slice; the slice logic is written for two bits
  localparam int unsigned SLICE_W  = 2;
  // number of flops in the clear-release synchronizer
  localparam int unsigned SYNC_LEN = 2;

  typedef struct packed {
    logic up;
    logic ld;
  } slice_ctl_t;
endpackage

// File: rtl/gcnt_rst_sync.sv
module gcnt_rst_sync
  import gcnt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  output logic hold_o
);
  logic [SYNC_LEN-1:0] sr_q;
  logic [SYNC_LEN-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[SYNC_LEN-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) sr_q <= '1;
    else       sr_q <= sr_d;
  end

  assign hold_o = sr_q[SYNC_LEN-1];
endmodule

// File: rtl/gcnt_slice.sv
module gcnt_slice
  import gcnt_pkg::*;
(
  input  logic               cin_i,
  input  slice_ctl_t         ctl_i,
  input  logic [SLICE_W-1:0] cur_i,
  input  logic [SLICE_W-1:0] ld_val_i,
  output logic [SLICE_W-1:0] nxt_o,
  output logic               cout_o
);
  logic lo_end;
  logic hi_end;
  logic inner;

  always_comb begin
    // a bit is at its end value when it is 1 (counting up) or 0 (counting down)
    lo_end = ctl_i.up ? cur_i[0] : ~cur_i[0];
    hi_end = ctl_i.up ? cur_i[1] : ~cur_i[1];
    inner  = cin_i & lo_end;
    cout_o = inner & hi_end;
    if (ctl_i.ld) nxt_o = ld_val_i;
    else          nxt_o = {cur_i[1] ^ inner, cur_i[0] ^ cin_i};
  end
endmodule

// File: rtl/gcnt_top.sv
module gcnt_top
  import gcnt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             ce_i,
  input  logic             ld_i,
  input  logic             up_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tc_o
);
  localparam int unsigned N_SLICE = CNT_W / SLICE_W;

  logic             rst_hold;
  logic [N_SLICE:0] carry;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  slice_ctl_t       ctl;

  gcnt_rst_sync u_sync (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .hold_o (rst_hold)
  );

  always_comb begin
    ctl.up = up_i;
    ctl.ld = ld_i;
  end

  assign carry[0] = ce_i;

  for (genvar g = 0; g < N_SLICE; g++) begin : g_slice
    gcnt_slice u_slice (
      .cin_i    (carry[g]),
      .ctl_i    (ctl),
      .cur_i    (cnt_q[g*SLICE_W +: SLICE_W]),
      .ld_val_i (ld_val_i[g*SLICE_W +: SLICE_W]),
      .nxt_o    (cnt_d[g*SLICE_W +: SLICE_W]),
      .cout_o   (carry[g+1])
    );
  end

  always_ff @(posedge clk_i or posedge rst_hold) begin
    if (rst_hold)          cnt_q <= '0;
    else if (ld_i || ce_i) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign tc_o  = carry[N_SLICE];
endmodule

// File: rtl/gcnt_chk.sv
module gcnt_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             hold_i,
  input logic             ce_i,
  input logic             ld_i,
  input logic             up_i,
  input logic [CNT_W-1:0] ld_val_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             tc_o
);
  localparam logic [CNT_W-1:0] ONES = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  AST_CLEAR_HELD: assert property (@(posedge clk_i)
    rst_i |-> cnt_o == '0); // R1

  AST_RELEASE_GAP: assert property (@(posedge clk_i)
    ($past(rst_i) && !rst_i) |-> cnt_o == '0); // R2

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (hold_i || rst_i)
    ld_i |=> cnt_o == $past(ld_val_i)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (hold_i || rst_i)
    (!ld_i && !ce_i) |=> $stable(cnt_o)); // R4

  AST_STEP_UP: assert property (@(posedge clk_i) disable iff (hold_i || rst_i)
    (!ld_i && ce_i && up_i) |=> cnt_o == $past(cnt_o) + ONE); // R5

  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (hold_i || rst_i)
    (!ld_i && ce_i && !up_i) |=> cnt_o == $past(cnt_o) - ONE); // R6

  AST_TERM_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
    tc_o == (ce_i && (up_i ? (cnt_o == ONES) : (cnt_o == '0)))); // R7
endmodule

bind gcnt_top gcnt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .hold_i   (rst_hold),
  .ce_i     (ce_i),
  .ld_i     (ld_i),
  .up_i     (up_i),
  .ld_val_i (ld_val_i),
  .cnt_o    (cnt_o),
  .tc_o     (tc_o)
);

// File: tb/gcnt_top_bench.sv
`timescale 1ns/1ps
module gcnt_top_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_i = 1'b1;
  logic         ce_i = 1'b0;
  logic         ld_i = 1'b0;
  logic         up_i = 1'b1;
  logic [W-1:0] ld_val_i = '0;
  logic [W-1:0] cnt_o;
  logic         tc_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [W-1:0] model = '0;
  int           skip  = 2;

  always #2.5 clk = ~clk;

  gcnt_top #(.CNT_W(W)) u_gcnt_top (
    .clk_i(clk), .rst_i(rst_i), .ce_i(ce_i), .ld_i(ld_i), .up_i(up_i),
    .ld_val_i(ld_val_i), .cnt_o(cnt_o), .tc_o(tc_o)
  );

  function automatic logic [W-1:0] exp_next(logic [W-1:0] q, logic ce, logic ld,
                                            logic up, logic [W-1:0] d);
    if (ld)      return d;
    else if (!ce) return q;
    else if (up) return q + 1'b1;
    else         return q - 1'b1;
  endfunction

  function automatic logic exp_tc(logic [W-1:0] q, logic ce, logic up);
    return ce && (up ? (q == '1) : (q == '0));
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge; drives, checks the flag, crosses one rising edge
  task automatic step(logic ce, logic ld, logic up, logic [W-1:0] d, string tag);
    ce_i = ce; ld_i = ld; up_i = up; ld_val_i = d;
    #0.5;
    check("R7 tc", {15'd0, tc_o}, {15'd0, exp_tc(model, ce, up)});
    @(posedge clk);
    if (rst_i) model = '0;
    else if (skip > 0) begin skip--; model = '0; end
    else model = exp_next(model, ce, ld, up, d);
    @(negedge clk);
    check(tag, cnt_o, model);
  endtask

  task automatic do_reset();
    rst_i = 1'b1; skip = 2; model = '0;
    @(negedge clk);
    check("R1 reset", cnt_o, '0);
    rst_i = 1'b0;
    step(1'b1, 1'b1, 1'b1, 16'hABCD, "R2 first edge");
    step(1'b1, 1'b1, 1'b0, 16'h1234, "R2 second edge");
    step(1'b0, 1'b1, 1'b1, 16'h5A5A, "R3 load after release");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();

    // up wrap
    step(1'b0, 1'b1, 1'b1, 16'hFFFE, "R3 load ce low");
    step(1'b1, 1'b0, 1'b1, 16'h0000, "R5 up");
    step(1'b1, 1'b0, 1'b1, 16'h0000, "R5 wrap up");
    step(1'b1, 1'b0, 1'b1, 16'h0000, "R5 up after wrap");
    // down wrap
    step(1'b1, 1'b1, 1'b0, 16'h0001, "R3 load ce high");
    step(1'b1, 1'b0, 1'b0, 16'h0000, "R6 down");
    step(1'b1, 1'b0, 1'b0, 16'h0000, "R6 wrap down");
    step(1'b1, 1'b0, 1'b0, 16'h0000, "R6 down after wrap");
    // hold, including at an end value
    step(1'b0, 1'b0, 1'b1, 16'h7777, "R4 hold");
    step(1'b1, 1'b1, 1'b1, 16'hFFFF, "R3 load top");
    step(1'b0, 1'b0, 1'b1, 16'h0000, "R4 hold at top");
    step(1'b1, 1'b1, 1'b0, 16'h00FF, "R3 load mid");
    step(1'b1, 1'b0, 1'b1, 16'h0000, "R5 carry through slices");

    for (int i = 0; i < 3000; i++) begin
      logic ld, ce, up;
      logic [W-1:0] d;
      string tag;
      ld = ($urandom % 16) == 0;
      ce = ($urandom % 4) != 0;
      up = $urandom % 2;
      case ($urandom % 4)
        0: d = 16'hFFFF - W'($urandom % 3);
        1: d = W'($urandom % 3);
        default: d = W'($urandom);
      endcase
      tag = ld ? "R3 rand" : (!ce ? "R4 rand" : (up ? "R5 rand" : "R6 rand"));
      step(ce, ld, up, d, tag);
    end

    // clear raised in the middle of a cycle
    step(1'b1, 1'b1, 1'b1, 16'hC3C3, "R3 before clear");
    #1;
    rst_i = 1'b1;
    #0.5;
    check("R1 async clear", cnt_o, '0);
    @(negedge clk);
    do_reset();
    step(1'b1, 1'b0, 1'b0, 16'h0000, "R6 after clear");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule